// File: doc/BRIEF.md
# Display and fetch window generator

This block tells a video pipeline where the visible playfield lies on the raster and when bitplane data must be fetched. It compares the beam position with a programmed window rectangle and raises `win_active` inside it. Outside the rectangle the pixel path shows the border colour, which is palette entry 0. It also compares a bus-cycle counter with a programmed fetch range and raises `fetch_active` while the DMA should be reading. A third output, `long_frame`, tracks the field parity when interlace is enabled.

The window corner registers hold 8-bit coordinates only. The block supplies the missing ninth bit of each coordinate from fixed rules. The start corner lives in the low half of the raster. The stop corner reaches the right half horizontally, and vertically it can reach beyond line 255. The stop corner is exclusive. The programmed fetch bounds are clamped into the legal bus-cycle range before they are compared.

Top module: `dispwin_gen`

## Requirements
- R1: After reset, the window corners are 0x2C81 and 0x2CC1, the fetch bounds are 0x38 and 0xD0, `win_active` is 0 and `long_frame` is 1.
- R2: The window start word gives the first vertical line in bits 15..8 and the first horizontal pixel in bits 7..0, each with a ninth bit of 0. A start of 0x2C81 makes line 44 and pixel 129 the first positions inside the window.
- R3: The window stop word gives the first line outside the window in bits 15..8 and the first pixel outside it in bits 7..0. The horizontal ninth bit is 1. With stop 0x2CC1, line 299 and pixel 448 are inside the window, and line 300 and pixel 449 are outside.
- R4: The vertical ninth bit of the stop coordinate is the inverse of stop bit 15. A stop of 0x90C1 therefore ends the window at line 144, not line 400.
- R5: The vertical in-window state is sampled only in the cycle where `hpos` is 0, and it applies from the next cycle. A change of `vpos` at any other horizontal position has no effect on `win_active`.
- R6: `win_active` is 1 only when both the vertical state and the horizontal comparison of the current `hpos` are inside the window.
- R7: `fetch_active` is 1 while the clamped fetch start is less than or equal to `bus_cyc`, and `bus_cyc` is at most the clamped fetch stop plus 7. This covers the final group of 8 fetch cycles.
- R8: A fetch start below 0x18 is treated as 0x18.
- R9: A fetch stop above 0xD8 is treated as 0xD8, so fetching never extends past cycle 0xDF.
- R10: While `lace_en` is 1, each cycle with `frame_start` set toggles `long_frame`. Otherwise `long_frame` holds its value.
- R11: While `lace_en` is 0, `long_frame` is 1 from the next cycle on, whatever `frame_start` does.
- R12: Register writes use `wr_sel`: 0 is window start, 1 is window stop, 2 is fetch start (bits 7..0) and 3 is fetch stop (bits 7..0). A write is captured on the clock edge where `wr_en` is 1. It affects the comparisons from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 9 | Horizontal beam position in pixels |
| vpos | input | 9 | Vertical beam line |
| bus_cyc | input | 8 | Horizontal bus-cycle counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for a write |
| wr_data | input | 16 | Write data |
| lace_en | input | 1 | Interlace enable |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| win_active | output | 1 | Beam is inside the display window |
| fetch_active | output | 1 | Bitplane fetch cycle range is active |
| long_frame | output | 1 | Current field is a long frame |

## Verification
The assertions assume that `hpos` passes through 0 once per line. They also assume that `bus_cyc` and `hpos` are driven as stable binary values between clock edges. The bench drives every input half a clock away from the active edge. It enters each line by holding `hpos` at 0 for one cycle. It changes `vpos` in the middle of a line only in the scenario that checks this change is ignored. Fetch bounds are written with values both inside and outside the legal range, so the clamping assertions meet both cases.

// File: rtl/dispwin_gen.sv
module dispwin_gen #(
  parameter int PW = 9,
  parameter int CW = 8,
  parameter logic [CW-1:0] FETCH_MIN = 8'h18,
  parameter logic [CW-1:0] FETCH_MAX = 8'hD8,
  parameter int FETCH_GRP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] hpos,
  input  logic [PW-1:0] vpos,
  input  logic [CW-1:0] bus_cyc,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [15:0]   wr_data,
  input  logic          lace_en,
  input  logic          frame_start,
  output logic          win_active,
  output logic          fetch_active,
  output logic          long_frame
);
  logic [15:0]   win_lo, win_hi;
  logic [CW-1:0] f_lo, f_hi;
  logic          v_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_lo <= 16'h2C81;
      win_hi <= 16'h2CC1;
      f_lo   <= 8'h38;
      f_hi   <= 8'hD0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: win_lo <= wr_data;
        2'd1: win_hi <= wr_data;
        2'd2: f_lo   <= wr_data[CW-1:0];
        default: f_hi <= wr_data[CW-1:0];
      endcase
    end
  end

  wire [PW-1:0] v_first = {1'b0, win_lo[15:8]};
  wire [PW-1:0] h_first = {1'b0, win_lo[7:0]};
  wire [PW-1:0] v_last  = {~win_hi[15], win_hi[15:8]};
  wire [PW-1:0] h_last  = {1'b1, win_hi[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) v_row <= 1'b0;
    else if (hpos == '0) v_row <= (vpos >= v_first) && (vpos < v_last);
  end

  wire h_in = (hpos >= h_first) && (hpos < h_last);
  assign win_active = v_row && h_in;

  wire [CW-1:0] f_lo_c = (f_lo < FETCH_MIN) ? FETCH_MIN : f_lo;
  wire [CW-1:0] f_hi_c = (f_hi > FETCH_MAX) ? FETCH_MAX : f_hi;
  wire [CW:0]   f_end  = {1'b0, f_hi_c} + CW'(FETCH_GRP);
  assign fetch_active = (bus_cyc >= f_lo_c) && ({1'b0, bus_cyc} < f_end);

  always_ff @(posedge clk) begin
    if (!rst_n)            long_frame <= 1'b1;
    else if (!lace_en)     long_frame <= 1'b1;
    else if (frame_start)  long_frame <= ~long_frame;
  end

  p_vrow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != '0) |=> $stable(v_row));
  p_win_needs_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> v_row);
  p_fetch_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_active |-> (bus_cyc >= FETCH_MIN));
  p_fetch_ceil_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_active |-> ({1'b0, bus_cyc} < ({1'b0, FETCH_MAX} + CW'(FETCH_GRP))));
  p_lof_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lace_en && frame_start) |=> (long_frame != $past(long_frame)));
  p_lof_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lace_en && !frame_start) |=> $stable(long_frame));
  p_lof_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lace_en |=> long_frame);
endmodule

// File: tb/dispwin_gen_bench.sv
module dispwin_gen_bench;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [8:0] hpos = 0, vpos = 0;
  logic [7:0] bus_cyc = 0;
  logic wr_en = 0, lace_en = 0, frame_start = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic win_active, fetch_active, long_frame;
  int n_cmp = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dispwin_gen u_dispwin_gen (.clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .bus_cyc(bus_cyc), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lace_en(lace_en), .frame_start(frame_start), .win_active(win_active),
    .fetch_active(fetch_active), .long_frame(long_frame));

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic enter_line(input int v);
    hpos = 0; vpos = 9'(v); tick();
  endtask

  task automatic win_at(input string req, input int h, input logic exp);
    hpos = 9'(h); #1; chk(req, win_active, exp);
  endtask

  task automatic fetch_at(input string req, input int b, input logic exp);
    bus_cyc = 8'(b); #1; chk(req, fetch_active, exp);
  endtask

  task automatic t_reset();
    #1; chk("R1 win", win_active, 0); chk("R1 lof", long_frame, 1);
    fetch_at("R1 fetch start", 8'h38, 1); fetch_at("R1 fetch below", 8'h37, 0);
  endtask

  task automatic t_start_stop();
    enter_line(43); win_at("R2 line 43", 200, 0);
    enter_line(44); win_at("R2 line 44", 200, 1);
    win_at("R2 px 128", 128, 0); win_at("R2 px 129", 129, 1);
    win_at("R3 px 448", 448, 1); win_at("R3 px 449", 449, 0);
    enter_line(299); win_at("R3 line 299", 300, 1);
    enter_line(300); win_at("R3 line 300", 300, 0);
  endtask

  task automatic t_stop_bit7();
    wr(1, 16'h90C1);
    enter_line(143); win_at("R4 line 143", 300, 1);
    enter_line(144); win_at("R4 line 144", 300, 0);
    wr(1, 16'h2CC1);
  endtask

  task automatic t_vsample();
    enter_line(50); win_at("R5 base", 200, 1);
    vpos = 10; tick(); win_at("R5 mid-line vpos ignored", 200, 1);
    enter_line(10); win_at("R5 next line", 200, 0);
    hpos = 5; vpos = 60; tick(); win_at("R5 vpos at hpos 5 ignored", 200, 0);
  endtask

  task automatic t_and();
    enter_line(100); win_at("R6 h outside", 20, 0); win_at("R6 both in", 300, 1);
    enter_line(20); win_at("R6 v outside", 300, 0);
  endtask

  task automatic t_write_timing();
    enter_line(100); win_at("R12 before write", 150, 1);
    wr(0, 16'h2CC8);
    win_at("R12 new hstart 150", 150, 0); win_at("R12 new hstart 200", 200, 1);
    wr(0, 16'h2C81);
  endtask

  task automatic t_fetch();
    fetch_at("R7 stop+7", 8'hD7, 1); fetch_at("R7 stop+8", 8'hD8, 0);
    wr(2, 16'h0040); wr(3, 16'h0080);
    fetch_at("R7 below start", 8'h3F, 0); fetch_at("R7 at start", 8'h40, 1);
    fetch_at("R7 last", 8'h87, 1); fetch_at("R7 past", 8'h88, 0);
    wr(2, 16'h0010);
    fetch_at("R8 clamp 0x17", 8'h17, 0); fetch_at("R8 clamp 0x18", 8'h18, 1);
    wr(3, 16'h00F0);
    fetch_at("R9 clamp 0xDF", 8'hDF, 1); fetch_at("R9 clamp 0xE0", 8'hE0, 0);
    fetch_at("R9 clamp 0xF5", 8'hF5, 0);
  endtask

  task automatic t_lace();
    lace_en = 1; frame_start = 1; tick(); frame_start = 0; #1;
    chk("R10 toggle 1", long_frame, 0);
    tick(); #1; chk("R10 hold", long_frame, 0);
    frame_start = 1; tick(); frame_start = 0; #1;
    chk("R10 toggle 2", long_frame, 1);
    frame_start = 1; tick(); frame_start = 0; #1;
    chk("R10 toggle 3", long_frame, 0);
    lace_en = 0; tick(); #1; chk("R11 forced set", long_frame, 1);
    frame_start = 1; tick(); frame_start = 0; #1;
    chk("R11 frame_start ignored", long_frame, 1);
  endtask

  initial begin
    repeat (2) tick();
    rst_n = 1;
    t_reset();
    t_start_stop();
    t_stop_bit7();
    t_vsample();
    t_and();
    t_write_timing();
    t_fetch();
    t_lace();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule